// File: doc/BRIEF.md
# Periodic Frame-List Schedule Walker

This block is the periodic-schedule engine of a full/low-speed USB host controller. Software places a page-sized table of 1024 word-wide frame entries in memory and tells the block where it sits through a base register. On every 1 ms frame tick, while running, the block reads the entry that the frame counter selects and then advances the counter. From that entry it follows link pointers through queue heads and transfer descriptors. It hands each active descriptor to a transaction port, one at a time, and writes the outcome back into the descriptor word it came from.

Memory traffic goes through a single word-wide request port. Each request stays up with a steady address until the memory acknowledges it, and read data is taken in the acknowledge cycle. The transaction side is a plain request/done stub that carries the descriptor's token word and returns an 8-bit result. A descriptor can ask for an interrupt on completion, which sets a sticky status bit that also drives the `irq` output. A frame tick that arrives while a walk is still in progress abandons that walk, raises a sticky overrun flag and starts the new frame. Clearing the run bit stops both the counter and the walker at the next tick.

Top module: `frame_walker`

## Requirements
- R1: After reset, all four registers read zero, `irq` is low and neither `mem_req` nor `xact_req` is asserted.
- R2: On a `frame_tick` with run set, the entry is read from address {base[31:12], F, 2'b00}, where F is the counter value before the tick. The counter then becomes (F+1) mod 1024, so 1023 is followed by 0. Base bits 11:0 do not affect the fetch.
- R3: Link pointer format: bit 0 = terminate, bit 1 = 1 for a queue head and 0 for a descriptor, bits 31:4 = 16-byte-aligned address, bits 3:2 ignored. An entry with bit 0 set causes no further memory reads and no transactions.
- R4: Descriptor layout: word +0 is the link, word +4 is control/status (bit 23 active, bit 24 interrupt-on-completion, bits 7:0 status), word +8 is the token. The token is presented on `xact_token`. Descriptors execute one at a time in link order.
- R5: Queue head layout: word +0 is the onward link and word +4 is the element link. The element chain is walked first. When it terminates, the walk resumes at the queue head's onward link.
- R6: A descriptor whose active bit is clear is skipped. It gets no transaction and no write-back, and the walk continues at its link.
- R7: After a transaction completes, word +4 is rewritten with bit 23 cleared, bits 7:0 set to `xact_result`, and all other bits unchanged.
- R8: Once the write-back of a descriptor with bit 24 set is acknowledged, status bit 0 is set and `irq` follows it. The bit stays set until software writes 1 to status bit 0.
- R9: A run-mode tick that arrives while a walk is in progress sets status bit 1 (sticky, cleared by writing 1 to status bit 1), abandons the old walk and starts the new frame.
- R10: With run clear, a tick fetches nothing and leaves the counter unchanged, and any walk in progress is abandoned without setting the overrun bit.
- R11: Register map by `reg_addr`: 0 = base (read back as written), 1 = frame counter in bits 9:0, 2 = run in bit 0, 3 = status (bit 0 interrupt, bit 1 overrun; write 1 to clear).
- R12: `mem_req` and `xact_req` are never high together. A memory request keeps its address until acknowledged unless a tick or a register write intervenes. Writes go only to descriptor offset +4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | One-cycle pulse marking each 1 ms frame start |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt, equal to status bit 0 |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge; read data valid in this cycle |
| mem_rdata | input | 32 | Memory read data |
| xact_req | output | 1 | Transaction request for the current descriptor |
| xact_token | output | 32 | Token word of the current descriptor |
| xact_done | input | 1 | Transaction complete |
| xact_result | input | 8 | Completion status to write back |

## Verification
The hardest situation to reach from the ports is a frame boundary that lands partway through a long walk. At that point the engine must drop a half-finished memory request or transaction, raise the overrun bit, and restart cleanly from a new entry without taking a stale acknowledge. The bench builds a six-descriptor chain, fires a tick, and fires the next tick a fixed handful of cycles later, before the chain can possibly finish. It repeats the same pattern with run cleared to reach the silent-abandon case. Random memory stall cycles and randomly shaped queue-head/descriptor schedules cover the rest of the walk, including the 1023-to-0 counter wrap.

// File: rtl/frame_walker.sv
module frame_walker #(
  parameter int FRAMES  = 1024,
  parameter int ACT_BIT = 23,
  parameter int IOC_BIT = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_tick,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        xact_req,
  output logic [31:0] xact_token,
  input  logic        xact_done,
  input  logic [7:0]  xact_result
);
  localparam int IW = $clog2(FRAMES);
  localparam int PW = IW + 2;
  localparam logic [31:0] CLR = (32'h1 << ACT_BIT) | 32'hFF;
  localparam logic [29:0] TERM = 30'h1;

  typedef enum logic [3:0] {
    S_IDLE, S_ENTRY, S_DEC, S_QH0, S_QH1, S_TD0, S_TD1, S_TD2, S_EXEC, S_WB
  } st_t;

  st_t           st;
  logic [31:0]   base, ctrl, token;
  logic [IW-1:0] frnum, fidx;
  logic          run, intr, ovr;
  logic [29:0]   nxt, resume;
  logic [27:0]   cur;
  logic [7:0]    res;

  wire set_intr = (st == S_WB) && mem_ack && ctrl[IOC_BIT];
  wire set_ovr  = frame_tick && run && (st != S_IDLE);

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = base;
      2'd1:    reg_rdata = {{(32-IW){1'b0}}, frnum};
      2'd2:    reg_rdata = {31'b0, run};
      default: reg_rdata = {30'b0, ovr, intr};
    endcase
  end

  always_comb begin
    case (st)
      S_ENTRY:            mem_addr = {base[31:PW], fidx, 2'b00};
      S_QH1, S_TD1, S_WB: mem_addr = {cur, 4'h4};
      S_TD2:              mem_addr = {cur, 4'h8};
      default:            mem_addr = {cur, 4'h0};
    endcase
  end

  assign mem_req    = st inside {S_ENTRY, S_QH0, S_QH1, S_TD0, S_TD1, S_TD2, S_WB};
  assign mem_we     = (st == S_WB);
  assign mem_wdata  = (ctrl & ~CLR) | {24'h0, res};
  assign xact_req   = (st == S_EXEC);
  assign xact_token = token;
  assign irq        = intr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; base <= '0; frnum <= '0; fidx <= '0; run <= 1'b0;
      intr <= 1'b0; ovr <= 1'b0; nxt <= TERM; resume <= TERM;
      cur <= '0; ctrl <= '0; token <= '0; res <= '0;
    end else begin
      if (frame_tick) begin
        if (run) begin
          fidx   <= frnum;
          frnum  <= frnum + 1'b1;
          resume <= TERM;
          st     <= S_ENTRY;
        end else begin
          st <= S_IDLE;
        end
      end else begin
        case (st)
          S_ENTRY: if (mem_ack) begin
            nxt <= {mem_rdata[31:4], mem_rdata[1:0]};
            st  <= S_DEC;
          end
          S_DEC: begin
            if (nxt[0]) begin
              if (!resume[0]) begin
                nxt    <= resume;
                resume <= TERM;
              end else begin
                st <= S_IDLE;
              end
            end else begin
              cur <= nxt[29:2];
              st  <= nxt[1] ? S_QH0 : S_TD0;
            end
          end
          S_QH0: if (mem_ack) begin
            resume <= {mem_rdata[31:4], mem_rdata[1:0]};
            st     <= S_QH1;
          end
          S_QH1: if (mem_ack) begin
            nxt <= {mem_rdata[31:4], mem_rdata[1:0]};
            st  <= S_DEC;
          end
          S_TD0: if (mem_ack) begin
            nxt <= {mem_rdata[31:4], mem_rdata[1:0]};
            st  <= S_TD1;
          end
          S_TD1: if (mem_ack) begin
            ctrl <= mem_rdata;
            st   <= mem_rdata[ACT_BIT] ? S_TD2 : S_DEC;
          end
          S_TD2: if (mem_ack) begin
            token <= mem_rdata;
            st    <= S_EXEC;
          end
          S_EXEC: if (xact_done) begin
            res <= xact_result;
            st  <= S_WB;
          end
          S_WB: if (mem_ack) st <= S_DEC;
          default: st <= S_IDLE;
        endcase
      end

      if (reg_wr) begin
        case (reg_addr)
          2'd0: base  <= reg_wdata;
          2'd1: frnum <= reg_wdata[IW-1:0];
          2'd2: run   <= reg_wdata[0];
          default: begin
            if (reg_wdata[0]) intr <= 1'b0;
            if (reg_wdata[1]) ovr  <= 1'b0;
          end
        endcase
      end
      if (set_intr) intr <= 1'b1;
      if (set_ovr)  ovr  <= 1'b1;
    end
  end
endmodule

// File: rtl/frame_walker_chk.sv
module frame_walker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_tick,
  input logic       reg_wr,
  input logic       clr_intr,
  input logic       irq,
  input logic       mem_req,
  input logic       mem_we,
  input logic [31:0] mem_addr,
  input logic       wb_active,
  input logic       mem_ack,
  input logic       xact_req,
  input logic       run,
  input logic       busy,
  input logic       ovr,
  input logic [9:0] frnum
);
  // R12
  a_r12_one_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && xact_req));
  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !frame_tick && !reg_wr) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  // R7
  a_r7_wb_clears_active: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !wb_active);
  // R8
  a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_intr) |=> irq);
  // R9
  a_r9_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && run && busy) |=> ovr);
  // R2
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && run && !reg_wr) |=> (frnum == 10'($past(frnum) + 10'd1)));
  // R10
  a_r10_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !reg_wr) |=> $stable(frnum));
endmodule

bind frame_walker frame_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .reg_wr(reg_wr),
  .clr_intr(reg_wr && reg_addr == 2'd3 && reg_wdata[0]),
  .irq(irq), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .wb_active(mem_wdata[23]), .mem_ack(mem_ack), .xact_req(xact_req),
  .run(run), .busy(st != S_IDLE), .ovr(ovr), .frnum(frnum)
);

// File: tb/frame_walker_bench.sv
module frame_walker_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_tick = 1'b0, reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq, mem_req, mem_we, mem_ack, xact_req, xact_done;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, xact_token;
  logic [7:0] xact_result;

  always #2 clk = ~clk;

  frame_walker u_frame_walker (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .xact_req(xact_req),
    .xact_token(xact_token), .xact_done(xact_done), .xact_result(xact_result)
  );

  localparam int FL = 'hC00;
  localparam int QH = 'h800;
  localparam logic [31:0] QHPTR = 32'h2002;

  logic [31:0] mem [0:4095];
  logic mrdy = 1'b0;
  logic [2:0] xcnt = '0;
  logic [31:0] tlog [0:1023];
  int ntok = 0, hs_bad = 0, checks = 0, errors = 0;

  always @(posedge clk) mrdy <= ($urandom % 3) != 0;
  assign mem_ack   = mem_req && mrdy;
  assign mem_rdata = mem[mem_addr[13:2]];
  always @(posedge clk) if (mem_req && mem_we && mem_ack) mem[mem_addr[13:2]] <= mem_wdata;

  always @(posedge clk) xcnt <= (!xact_req || xact_done) ? 3'd0 : xcnt + 3'd1;
  assign xact_done   = xact_req && (xcnt == 3'd2);
  assign xact_result = xact_token[7:0] ^ xact_token[15:8];
  always @(posedge clk) if (xact_req && xact_done) begin
    tlog[ntok] <= xact_token;
    ntok <= ntok + 1;
  end

  always @(posedge clk)
    if (rst_n && ((mem_req && xact_req) || (mem_req && mem_we && mem_addr[3:0] != 4'h4)))
      hs_bad <= hs_bad + 1;

  function automatic logic [31:0] td_ptr(input int i);
    return 32'h1000 + 32'(16 * i);
  endfunction
  function automatic logic [31:0] exp_wb(input logic [31:0] c, input logic [31:0] t);
    return {c[31:24], 1'b0, c[22:8], t[7:0] ^ t[15:8]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask
  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask
  task automatic tick();
    @(negedge clk); frame_tick = 1'b1;
    @(negedge clk); frame_tick = 1'b0;
  endtask
  task automatic put_td(input int i, input logic [31:0] lk, input logic [31:0] c, input logic [31:0] t);
    mem['h400 + 4*i] = lk; mem['h401 + 4*i] = c; mem['h402 + 4*i] = t;
  endtask
  task automatic chain6();
    for (int i = 0; i < 6; i++)
      put_td(i, (i == 5) ? 32'h1 : td_ptr(i + 1), 32'h0080_0000 | 32'(i), 32'h100 * 32'(i + 1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int s0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4096; i++) mem[i] = 32'h1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d); check("R1 register reset", d, 32'h0);
    end
    #1;
    check("R1 irq reset", {31'b0, irq}, 32'h0);
    check("R1 no request", {30'b0, mem_req, xact_req}, 32'h0);

    wr(0, 32'h0000_3ABC); rd(0, d); check("R11 base readback", d, 32'h0000_3ABC);
    wr(1, 32'hFFFF_F3FF); rd(1, d); check("R11 counter field", d, 32'h3FF);
    wr(3, 32'h3); rd(3, d); check("R11 status clear", d, 32'h0);

    put_td(0, 32'h1, 32'h0080_0011, 32'h0000_AB12);
    mem[FL + 5] = td_ptr(0);
    wr(1, 5); s0 = ntok; tick(); repeat (200) @(negedge clk);
    rd(1, d); check("R10 counter held", d, 32'd5);
    check("R10 no transaction", 32'(ntok - s0), 32'd0);
    check("R10 descriptor untouched", mem['h401], 32'h0080_0011);
    mem[FL + 5] = 32'h1;

    wr(2, 1);
    mem[FL + 1023] = td_ptr(0);
    wr(1, 1023); s0 = ntok; tick(); repeat (300) @(negedge clk);
    rd(1, d); check("R2 wrap to 0", d, 32'd0);
    check("R2 entry at top index", 32'(ntok - s0), 32'd1);
    check("R4 token", tlog[s0], 32'h0000_AB12);
    check("R7 write-back", mem['h401], exp_wb(32'h0080_0011, 32'h0000_AB12));
    mem[FL + 1023] = 32'h1;

    put_td(0, 32'h1, 32'h0180_0000, 32'h0000_0033);
    mem[FL + 7] = td_ptr(0) | 32'h1;
    wr(1, 7); s0 = ntok; tick(); repeat (200) @(negedge clk);
    check("R3 terminated entry", 32'(ntok - s0), 32'd0);
    mem[FL + 7] = 32'h1;

    put_td(0, td_ptr(1), 32'h0100_0000, 32'h0000_00AA);
    put_td(1, 32'h1, 32'h0180_0000, 32'h0000_00BB);
    put_td(2, 32'h1, 32'h0080_0000, 32'h0000_00CC);
    mem[QH] = td_ptr(2); mem[QH + 1] = td_ptr(0);
    mem[FL + 9] = QHPTR;
    wr(1, 9); s0 = ntok; tick(); repeat (300) @(negedge clk);
    check("R5 count", 32'(ntok - s0), 32'd2);
    check("R5 element first", tlog[s0], 32'h0000_00BB);
    check("R5 onward next", tlog[s0 + 1], 32'h0000_00CC);
    check("R6 inactive untouched", mem['h401], 32'h0100_0000);
    #1; check("R8 irq set", {31'b0, irq}, 32'h1);
    mem[FL + 9] = 32'h1;
    wr(1, 10); tick(); repeat (100) @(negedge clk);
    #1; check("R8 irq sticky", {31'b0, irq}, 32'h1);
    wr(3, 1); #1; check("R8 irq cleared", {31'b0, irq}, 32'h0);

    chain6();
    mem[FL + 20] = td_ptr(0); mem[FL + 21] = 32'h1;
    wr(1, 20); s0 = ntok; tick(); repeat (15) @(negedge clk);
    tick(); repeat (300) @(negedge clk);
    rd(3, d); check("R9 overrun set", d & 32'h2, 32'h2);
    check("R9 walk abandoned", 32'(ntok - s0 < 6), 32'h1);
    rd(1, d); check("R9 new frame counted", d, 32'd22);
    wr(3, 2); rd(3, d); check("R9 overrun cleared", d & 32'h2, 32'h0);
    wr(3, 1);

    chain6();
    wr(1, 20); s0 = ntok; tick(); repeat (15) @(negedge clk);
    wr(2, 0); tick(); repeat (300) @(negedge clk);
    rd(3, d); check("R10 abandon no overrun", d & 32'h2, 32'h0);
    check("R10 walk abandoned", 32'(ntok - s0 < 6), 32'h1);
    mem[FL + 20] = 32'h1; mem[FL + 21] = 32'h1;
    wr(2, 1); wr(3, 3);

    for (int it = 0; it < 40; it++) begin
      int n, m, k;
      logic shb, eirq;
      logic [9:0] f;
      logic [31:0] ctl [0:5];
      logic [31:0] tok [0:5];
      n = 1 + int'($urandom % 6);
      shb = 1'($urandom % 2);
      m = shb ? int'($urandom % (n + 1)) : n;
      f = (it == 0) ? 10'd1022 : 10'($urandom);
      eirq = 1'b0;
      for (int i = 0; i < n; i++) begin
        tok[i] = $urandom; ctl[i] = $urandom;
        ctl[i][23] = ($urandom % 4) != 0;
        put_td(i, (i == m - 1 || i == n - 1) ? 32'h1 : td_ptr(i + 1), ctl[i], tok[i]);
        if (ctl[i][23] && ctl[i][24]) eirq = 1'b1;
      end
      if (shb) begin
        mem[QH] = (n > m) ? td_ptr(m) : 32'h1;
        mem[QH + 1] = (m > 0) ? td_ptr(0) : 32'h1;
        mem[FL + int'(f)] = QHPTR;
      end else begin
        mem[FL + int'(f)] = td_ptr(0);
      end
      wr(1, 32'(f)); s0 = ntok; tick(); repeat (400) @(negedge clk);
      k = 0;
      for (int i = 0; i < n; i++) begin
        if (ctl[i][23]) begin
          check("R4 order", tlog[s0 + k], tok[i]);
          check("R7 random write-back", mem['h401 + 4*i], exp_wb(ctl[i], tok[i]));
          k++;
        end else begin
          check("R6 random skip", mem['h401 + 4*i], ctl[i]);
        end
      end
      check("R4 count", 32'(ntok - s0), 32'(k));
      #1; check("R8 random irq", {31'b0, irq}, {31'b0, eirq});
      rd(1, d); check("R2 random counter", d, 32'(10'(f + 10'd1)));
      rd(3, d); check("R9 no overrun", d & 32'h2, 32'h0);
      wr(3, 3);
      mem[FL + int'(f)] = 32'h1;
    end

    check("R12 handshake monitor", 32'(hs_bad), 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule